// File: doc/BRIEF.md
# Serial LED Output Shifter

This block drives a row of up to seventeen LED outputs through a chain of external serial-in, parallel-out shift registers using three lines: serial data, shift clock and a storage strobe. Software writes a data word together with a start flag. The block then sends the word one bit per shift-clock period, most significant bit first. In the latched chip style it follows the last bit with a strobe pulse that moves the shifted word onto the register outputs.

The shift clock is derived from the system clock by a divisor chosen from a coded set of four. A programmable delay sets how long after each falling shift-clock edge the next data bit appears. Hardware clamps that delay to the legal range. A second chip style needs no strobe and ends the transfer after the last bit. In follow mode the block ignores the stored word and keeps streaming a live vector taken from a bank of waveform generators. It samples that vector afresh at the start of each frame.

Top module: `sled_shifter`

## Requirements
- R1: After reset, all three serial lines are low and the start flag (bit 31 at address 0) reads 0. The divisor code at address 1 reads 3, the delay at address 2 reads 1, and the mode register at address 3 reads 0.
- R2: A write to address 0 with bit 31 set while the block is idle starts a transfer of bits 16..0. Bit 31 reads 1 from the first cycle of the transfer until the transfer ends, and reads 0 once the transfer has ended.
- R3: Exactly 17 rising shift-clock edges occur per frame. Sampling the data line on each rising edge yields word bits 16 down to 0 in that order.
- R4: The shift-clock period is 4, 8, 16 or 32 system clocks for divisor codes 0, 1, 2 and 3 (address 1, bits 1..0). The clock is low for the first half of each period and high for the second half.
- R5: With an effective delay D, the data line changes D-1 system clocks after each falling shift-clock edge. The start of the frame counts as such an edge.
- R6: A delay value (address 2, bits 4..0) of 0 acts as 1. A value above half the divisor acts as half the divisor.
- R7: In latched chip style (address 3 bit 0 = 0), the strobe rises on the falling edge after the 17th bit and stays high for exactly one shift-clock period. During the strobe the clock and data lines are low. The frame lasts 18 periods in total.
- R8: In strobe-free chip style (address 3 bit 0 = 1), no strobe pulse occurs. The frame ends after 17 periods with all lines low.
- R9: A write to address 0 during a transfer is ignored. The word in flight, the stored word that reads back at address 0 and the start of later frames are all unaffected.
- R10: While follow mode (address 3 bit 1) is set, frames run back to back. Each frame sends the waveform-generator vector as it stands at the frame's start. Clearing the bit lets the current frame finish and no further frame starts.
- R11: Addresses 1, 2 and 3 read back the raw values last written, including delay values that the hardware clamps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| pwm_vec | input | 17 | Live vector from the waveform-generator bank |
| sled_data_o | output | 1 | Serial data line |
| sled_clk_o | output | 1 | Shift clock line |
| sled_latch_o | output | 1 | Storage strobe line |

## Verification
The bench builds the block with its defaults: 17 data bits, a base divisor of 4 with a two-bit code, and a five-bit delay field. This makes all four shift-clock rates reachable. Delay values of 0 and of 31, which exceeds half of every divisor, exercise both clamp bounds. Each frame is decoded as an external register would see it, by sampling data on rising clock edges. Edge spacing, data-change offsets, strobe width and frame length are all measured in system cycles.

// File: rtl/sled_pkg.sv
package sled_pkg;
    typedef enum logic [1:0] {
        SL_IDLE  = 2'd0,
        SL_SHIFT = 2'd1,
        SL_LATCH = 2'd2
    } sled_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_DIV  = 2'd1;
    localparam logic [1:0] ADDR_DLY  = 2'd2;
    localparam logic [1:0] ADDR_MODE = 2'd3;
endpackage

// File: rtl/sled_timing.sv
// Decodes the frame's divisor code into period and half-period counts and
// clamps the programmed data delay to the range [1, half].
module sled_timing #(
    parameter int DIV_BASE_LOG2 = 2,
    parameter int DIV_CODE_W    = 2,
    parameter int DLY_W         = 5,
    parameter int CNT_W         = 5
) (
    input  logic [DIV_CODE_W-1:0] div_code,
    input  logic [DLY_W-1:0]      dly_raw,
    output logic [CNT_W-1:0]      period_m1,
    output logic [CNT_W-1:0]      half,
    output logic [CNT_W-1:0]      dly_eff
);
    localparam int XW = (CNT_W > DLY_W) ? CNT_W : DLY_W;

    logic [XW-1:0] half_x;
    logic [XW-1:0] raw_x;

    always_comb begin
        half      = CNT_W'(1) << (DIV_BASE_LOG2 - 1 + int'(div_code));
        period_m1 = (half << 1) - CNT_W'(1);
        half_x    = XW'(half);
        raw_x     = XW'(dly_raw);
        if (raw_x == '0) begin
            dly_eff = CNT_W'(1);
        end else if (raw_x > half_x) begin
            dly_eff = half;
        end else begin
            dly_eff = CNT_W'(raw_x);
        end
    end
endmodule

// File: rtl/sled_regs.sv
// Software-visible registers: data word with start flag, divisor code,
// delay and mode bits.
module sled_regs
    import sled_pkg::*;
#(
    parameter int NBITS      = 17,
    parameter int DATA_W     = 32,
    parameter int DIV_CODE_W = 2,
    parameter int DLY_W      = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [1:0]            rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    input  logic                  busy_i,
    output logic                  sw_start_o,
    output logic [NBITS-1:0]      sw_word_o,
    output logic [DIV_CODE_W-1:0] div_code_o,
    output logic [DLY_W-1:0]      dly_raw_o,
    output logic                  chip_alt_o,
    output logic                  follow_o
);
    localparam int FLAG = DATA_W - 1;

    typedef struct packed {
        logic [NBITS-1:0]      data;
        logic [DIV_CODE_W-1:0] div;
        logic [DLY_W-1:0]      dly;
        logic                  alt;
        logic                  follow;
    } regs_t;

    regs_t r_d, r_q;
    logic  unused_wr_bits;

    assign unused_wr_bits = ^wr_data[FLAG-1:NBITS];

    always_comb begin
        r_d        = r_q;
        sw_start_o = 1'b0;
        sw_word_o  = wr_data[NBITS-1:0];
        if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL: begin
                    if (!busy_i) begin
                        r_d.data = wr_data[NBITS-1:0];
                        if (wr_data[FLAG] && !r_q.follow) begin
                            sw_start_o = 1'b1;
                        end
                    end
                end
                ADDR_DIV:  r_d.div = wr_data[DIV_CODE_W-1:0];
                ADDR_DLY:  r_d.dly = wr_data[DLY_W-1:0];
                default: begin
                    r_d.alt    = wr_data[0];
                    r_d.follow = wr_data[1];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.data   <= '0;
            r_q.div    <= '1;
            r_q.dly    <= DLY_W'(1);
            r_q.alt    <= 1'b0;
            r_q.follow <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_CTRL: begin
                rd_data[NBITS-1:0] = r_q.data;
                rd_data[FLAG]      = busy_i;
            end
            ADDR_DIV:  rd_data[DIV_CODE_W-1:0] = r_q.div;
            ADDR_DLY:  rd_data[DLY_W-1:0]      = r_q.dly;
            default: begin
                rd_data[0] = r_q.alt;
                rd_data[1] = r_q.follow;
            end
        endcase
    end

    assign div_code_o = r_q.div;
    assign dly_raw_o  = r_q.dly;
    assign chip_alt_o = r_q.alt;
    assign follow_o   = r_q.follow;

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CTRL && wr_data[FLAG] && !busy_i && !r_q.follow)
        |=> busy_i);

    // R9
    ignore_busy_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CTRL && busy_i) |=> $stable(r_q.data));
endmodule

// File: rtl/sled_seq.sv
// Frame sequencer: shift phase counter, bit counter, serial line generation.
module sled_seq
    import sled_pkg::*;
#(
    parameter int NBITS      = 17,
    parameter int DIV_CODE_W = 2,
    parameter int DLY_W      = 5,
    parameter int CNT_W      = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sw_start_i,
    input  logic [NBITS-1:0]      sw_word_i,
    input  logic                  follow_i,
    input  logic [NBITS-1:0]      pwm_vec_i,
    input  logic [DIV_CODE_W-1:0] div_code_i,
    input  logic [DLY_W-1:0]      dly_raw_i,
    input  logic                  chip_alt_i,
    input  logic [CNT_W-1:0]      period_m1_i,
    input  logic [CNT_W-1:0]      half_i,
    input  logic [CNT_W-1:0]      dly_eff_i,
    output logic [DIV_CODE_W-1:0] frame_code_o,
    output logic [DLY_W-1:0]      frame_dly_o,
    output logic                  busy_o,
    output logic                  sdata_o,
    output logic                  sclk_o,
    output logic                  latch_o
);
    localparam int              BIT_W = $clog2(NBITS);
    localparam logic [BIT_W-1:0] LAST = BIT_W'(NBITS - 1);

    typedef struct packed {
        sled_state_e           st;
        logic [CNT_W-1:0]      cnt;
        logic [BIT_W-1:0]      bitidx;
        logic [NBITS-1:0]      shreg;
        logic [DIV_CODE_W-1:0] code;
        logic [DLY_W-1:0]      dly;
        logic                  alt;
        logic                  sdata;
        logic                  sclk;
        logic                  latch;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            SL_IDLE: begin
                // Track the registers while idle so a frame starts with them.
                s_d.code = div_code_i;
                s_d.dly  = dly_raw_i;
                s_d.alt  = chip_alt_i;
                if (follow_i || sw_start_i) begin
                    s_d.st     = SL_SHIFT;
                    s_d.cnt    = '0;
                    s_d.bitidx = '0;
                    s_d.shreg  = follow_i ? pwm_vec_i : sw_word_i;
                end
            end
            SL_SHIFT: begin
                if (s_q.cnt == period_m1_i) begin
                    s_d.cnt = '0;
                    if (s_q.bitidx == LAST) begin
                        s_d.st = s_q.alt ? SL_IDLE : SL_LATCH;
                    end else begin
                        s_d.bitidx = s_q.bitidx + BIT_W'(1);
                        s_d.shreg  = s_q.shreg << 1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
            default: begin
                if (s_q.cnt == period_m1_i) begin
                    s_d.st  = SL_IDLE;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
        endcase

        s_d.sclk  = (s_d.st == SL_SHIFT) && (s_d.cnt >= half_i);
        s_d.latch = (s_d.st == SL_LATCH);
        if (s_d.st != SL_SHIFT) begin
            s_d.sdata = 1'b0;
        end else if (s_d.cnt == dly_eff_i - CNT_W'(1)) begin
            s_d.sdata = s_d.shreg[NBITS-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st     <= SL_IDLE;
            s_q.cnt    <= '0;
            s_q.bitidx <= '0;
            s_q.shreg  <= '0;
            s_q.code   <= '1;
            s_q.dly    <= DLY_W'(1);
            s_q.alt    <= 1'b0;
            s_q.sdata  <= 1'b0;
            s_q.sclk   <= 1'b0;
            s_q.latch  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign frame_code_o = s_q.code;
    assign frame_dly_o  = s_q.dly;
    assign busy_o       = (s_q.st != SL_IDLE);
    assign sdata_o      = s_q.sdata;
    assign sclk_o       = s_q.sclk;
    assign latch_o      = s_q.latch;

    // R7
    latch_after_last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.latch) |-> ($past(s_q.st) == SL_SHIFT && $past(s_q.bitidx) == LAST));

    // R7
    latch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.latch |-> (!s_q.sclk && !s_q.sdata));

    // R5
    data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(s_q.sdata) && s_q.st == SL_SHIFT && $past(s_q.st) == SL_SHIFT)
        |-> (s_q.cnt == dly_eff_i - CNT_W'(1)));

    // R4
    sclk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.sclk) |-> (s_q.cnt == '0));
endmodule

// File: rtl/sled_shifter.sv
module sled_shifter #(
    parameter int NBITS         = 17,
    parameter int DATA_W        = 32,
    parameter int DIV_BASE_LOG2 = 2,
    parameter int DIV_CODE_W    = 2,
    parameter int DLY_W         = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NBITS-1:0]  pwm_vec,
    output logic              sled_data_o,
    output logic              sled_clk_o,
    output logic              sled_latch_o
);
    localparam int CNT_W = DIV_BASE_LOG2 + (1 << DIV_CODE_W) - 1;

    logic                  busy;
    logic                  sw_start;
    logic [NBITS-1:0]      sw_word;
    logic [DIV_CODE_W-1:0] div_code;
    logic [DLY_W-1:0]      dly_raw;
    logic                  chip_alt;
    logic                  follow;
    logic [DIV_CODE_W-1:0] frame_code;
    logic [DLY_W-1:0]      frame_dly;
    logic [CNT_W-1:0]      period_m1;
    logic [CNT_W-1:0]      half;
    logic [CNT_W-1:0]      dly_eff;

    sled_regs #(
        .NBITS(NBITS), .DATA_W(DATA_W), .DIV_CODE_W(DIV_CODE_W), .DLY_W(DLY_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .busy_i(busy),
        .sw_start_o(sw_start), .sw_word_o(sw_word),
        .div_code_o(div_code), .dly_raw_o(dly_raw),
        .chip_alt_o(chip_alt), .follow_o(follow)
    );

    sled_timing #(
        .DIV_BASE_LOG2(DIV_BASE_LOG2), .DIV_CODE_W(DIV_CODE_W),
        .DLY_W(DLY_W), .CNT_W(CNT_W)
    ) u_timing (
        .div_code(frame_code), .dly_raw(frame_dly),
        .period_m1(period_m1), .half(half), .dly_eff(dly_eff)
    );

    sled_seq #(
        .NBITS(NBITS), .DIV_CODE_W(DIV_CODE_W), .DLY_W(DLY_W), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .sw_start_i(sw_start), .sw_word_i(sw_word),
        .follow_i(follow), .pwm_vec_i(pwm_vec),
        .div_code_i(div_code), .dly_raw_i(dly_raw), .chip_alt_i(chip_alt),
        .period_m1_i(period_m1), .half_i(half), .dly_eff_i(dly_eff),
        .frame_code_o(frame_code), .frame_dly_o(frame_dly),
        .busy_o(busy),
        .sdata_o(sled_data_o), .sclk_o(sled_clk_o), .latch_o(sled_latch_o)
    );
endmodule

// File: tb/sled_shifter_tb.sv
module sled_shifter_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [16:0] pwm_vec = '0;
    logic        sdata, sclk, latch;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    sled_shifter u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_vec(pwm_vec),
        .sled_data_o(sdata), .sled_clk_o(sclk), .sled_latch_o(latch)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Watches one frame from its first cycle (phase 0) until the flag drops.
    task automatic watch_frame(input logic [16:0] exp, input int code, input int dly,
                               input bit alt, input int inj_cyc,
                               input logic [31:0] inj_data, input string tag);
        int n = 4 << code;
        int h = 2 << code;
        int cyc = 0, rises = 0, fall_c = 0, rise_c = 0, lat_c = 0;
        bit lat_seen = 0, lat_done = 0, done = 0;
        logic [16:0] model = '0;
        logic ps, pd, pl;
        check(rd_data[31] === 1'b1, {"R2 flag set ", tag}, rd_data[31], 1);
        ps = sclk; pd = sdata; pl = latch;
        while (!done && cyc < 40 * n) begin
            if (inj_cyc > 0 && cyc == inj_cyc) begin
                wr_en = 1'b1; wr_addr = 2'd0; wr_data = inj_data;
            end
            @(negedge clk);
            wr_en = 1'b0;
            cyc++;
            if (sclk && !ps) begin
                rises++;
                model = {model[15:0], sdata};
                check(cyc - fall_c == h, {"R4 low half ", tag}, cyc - fall_c, h);
                rise_c = cyc;
            end
            if (!sclk && ps) begin
                check(cyc - rise_c == h, {"R4 high half ", tag}, cyc - rise_c, h);
                fall_c = cyc;
            end
            if (sdata !== pd && rises < 17 && !latch) begin
                check(cyc - fall_c == dly - 1, {"R5 data offset ", tag}, cyc - fall_c, dly - 1);
            end
            if (latch && !pl) begin
                lat_seen = 1;
                lat_c = cyc;
                check(rises == 17, {"R7 strobe after last bit ", tag}, rises, 17);
            end
            if (!latch && pl) begin
                lat_done = 1;
                check(cyc - lat_c == n, {"R7 strobe width ", tag}, cyc - lat_c, n);
            end
            if (latch) begin
                check(!sclk && !sdata, {"R7 quiet during strobe ", tag}, {sclk, sdata}, 0);
            end
            if (rd_data[31] === 1'b0) done = 1;
            ps = sclk; pd = sdata; pl = latch;
        end
        check(done, {"R2 flag clears ", tag}, done, 1);
        check(rises == 17, {"R3 edge count ", tag}, rises, 17);
        check(model == exp, {"R3 shifted word ", tag}, model, exp);
        if (alt) begin
            check(!lat_seen && cyc == 17 * n, {"R8 no strobe, length ", tag}, cyc, 17 * n);
        end else begin
            check(lat_done && cyc == 18 * n, {"R7 frame length ", tag}, cyc, 18 * n);
        end
        check({sclk, sdata, latch} == 3'b000, {"R7 R8 idle lines ", tag}, {sclk, sdata, latch}, 0);
    endtask

    task automatic t_reset();
        check({sclk, sdata, latch} == 3'b000, "R1 lines low", {sclk, sdata, latch}, 0);
        rd_addr = 2'd0; #1;
        check(rd_data[31] == 1'b0, "R1 flag clear", rd_data[31], 0);
        rd_addr = 2'd1; #1;
        check(rd_data == 32'd3, "R1 divisor code", rd_data, 3);
        rd_addr = 2'd2; #1;
        check(rd_data == 32'd1, "R1 delay", rd_data, 1);
        rd_addr = 2'd3; #1;
        check(rd_data == 32'd0, "R1 mode", rd_data, 0);
        rd_addr = 2'd0;
    endtask

    task automatic run_sw(input logic [16:0] w, input int code, input int dly_raw,
                          input int dly_eff, input bit alt, input string tag);
        reg_wr(2'd1, 32'(code));
        reg_wr(2'd2, 32'(dly_raw));
        reg_wr(2'd3, {31'd0, alt});
        reg_wr(2'd0, {1'b1, 14'd0, w});
        watch_frame(w, code, dly_eff, alt, 0, '0, tag);
    endtask

    task automatic t_frames();
        run_sw(17'h15555, 0, 1, 1, 1'b0, "div4 d1");
        run_sw(17'h0AAAA, 1, 3, 3, 1'b0, "div8 d3");
        run_sw(17'h1F00F, 2, 8, 8, 1'b0, "div16 d8");
        run_sw(17'h12345, 3, 16, 16, 1'b1, "div32 d16 alt R8");
        run_sw(17'h0F0F1, 1, 2, 2, 1'b1, "div8 d2 alt R8");
    endtask

    task automatic t_clamp();
        run_sw(17'h15555, 0, 0, 1, 1'b0, "R6 low clamp");
        run_sw(17'h0AAAA, 1, 31, 4, 1'b0, "R6 high clamp");
    endtask

    task automatic t_busy_write();
        bit quiet = 1;
        reg_wr(2'd1, 32'd0);
        reg_wr(2'd2, 32'd2);
        reg_wr(2'd3, 32'd0);
        reg_wr(2'd0, {1'b1, 14'd0, 17'h1C3A5});
        watch_frame(17'h1C3A5, 0, 2, 1'b0, 20, {1'b1, 14'd0, 17'h00F0F}, "R9 ignored write");
        check(rd_data[16:0] == 17'h1C3A5, "R9 stored word kept", rd_data[16:0], 17'h1C3A5);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (sclk || rd_data[31]) quiet = 0;
        end
        check(quiet, "R9 no later frame", quiet, 1);
    endtask

    task automatic t_follow();
        bit quiet = 1;
        bit ended = 0;
        reg_wr(2'd1, 32'd0);
        reg_wr(2'd2, 32'd1);
        pwm_vec = 17'h1A5C3;
        reg_wr(2'd3, 32'd2);
        @(negedge clk);
        watch_frame(17'h1A5C3, 0, 1, 1'b0, 0, '0, "R10 frame 1");
        pwm_vec = 17'h05A3C;
        @(negedge clk);
        watch_frame(17'h05A3C, 0, 1, 1'b0, 0, '0, "R10 frame 2");
        pwm_vec = 17'h10001;
        @(negedge clk);
        check(rd_data[31] == 1'b1, "R10 back-to-back frame", rd_data[31], 1);
        reg_wr(2'd3, 32'd0);
        for (int i = 0; i < 200 && !ended; i++) begin
            @(negedge clk);
            if (rd_data[31] == 1'b0) ended = 1;
        end
        check(ended, "R10 current frame finishes", ended, 1);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (sclk || latch || rd_data[31]) quiet = 0;
        end
        check(quiet, "R10 stops after clear", quiet, 1);
    endtask

    task automatic t_readback();
        reg_wr(2'd1, 32'd2);
        reg_wr(2'd2, 32'd29);
        reg_wr(2'd3, 32'd1);
        rd_addr = 2'd1; #1;
        check(rd_data == 32'd2, "R11 divisor readback", rd_data, 2);
        rd_addr = 2'd2; #1;
        check(rd_data == 32'd29, "R11 raw delay readback", rd_data, 29);
        rd_addr = 2'd3; #1;
        check(rd_data == 32'd1, "R11 mode readback", rd_data, 1);
        rd_addr = 2'd0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_frames();
        t_clamp();
        t_busy_write();
        t_follow();
        t_readback();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule